// File: doc/BRIEF.md
# Hub Battery-Charging Configuration Register with Port Mode Decoder

This block holds one byte of battery-charging configuration for a four-port USB hub. It turns that byte, the upstream connection state and the per-port charging enables into a charging mode for each downstream port. A simple bus with address, write enable, write data and read data reaches the register.

A second path loads the same byte from external non-volatile memory. A mode flag selects which of the two paths may write. Two fields come from strap pins. They are captured on the first clock edge after the synchronous reset is released. Two other fields follow fused defaults until a custom-enable field is set, and only then hold written values. The power-switch control outputs are the power requests passed through or inverted, according to the polarity field.

A small sequencer has two named states. `ST_HOLD` is held while reset is asserted and lasts for the first clock after release. In that state the straps are sampled. The transition `ST_HOLD -> ST_RUN` happens on the first edge with reset low. `ST_RUN` is then held until the next reset (`ST_RUN -> ST_HOLD` on reset).

Top module: `chgcfg_top`

## Requirements
- R1: Reading at address `CFG_ADDR` (default 4'hA) returns the register byte, in which bits 7 and 0 are always 0. Bit 2 is a spare bit that resets to 0 and holds the last value written to it. Reading at any other address returns 8'h00.
- R2: Bit 6 (custom enable) resets to 0. While it is 0, bits 4 and 3 read back the fused inputs `otp_fast_div` and `otp_attach_det`, and writes to bits 4 and 3 are ignored.
- R3: An accepted write with bit 6 = 1 stores bits 4 and 3 from the same write data. While bit 6 stays 1, those stored values are read back.
- R4: On the first clock edge with `rst` low after reset, bit 5 takes `strap_pwr_pol` and bit 1 takes `strap_auto_off`. All other fields are 0 after reset. An accepted write in that same cycle takes priority over the straps.
- R5: With `load_sel` = 1 only `ld_valid` writes `ld_data` into the register. With `load_sel` = 0 only `bus_we` with `bus_addr == CFG_ADDR` writes `bus_wdata`. Writes on the unselected path, and bus writes at other addresses, change nothing.
- R6: `pwr_ctl[i]` equals `pwr_req[i]` when bit 5 is 1, and `~pwr_req[i]` when bit 5 is 0. It follows a change of bit 5 in the cycle after the write.
- R7: A port whose `port_chg_en` bit is 0 reports mode 2'b00 (off). The mode encoding is 00 off, 01 dedicated charger, 10 charging downstream, 11 automatic.
- R8: With `up_conn` = 0, an enabled port reports 2'b11 when bit 1 is 0 and 2'b01 when bit 1 is 1.
- R9: With `up_conn` = 1, an enabled port reports 2'b10, whatever bit 1 holds. The exception is port index 0 while bit 1 is 0: it reports 2'b00.
- R10: `fast_div_sel` equals the effective bit 4 as read back. `attach_det_en` equals the effective bit 3 when bit 1 is 0, and is 0 when bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_we | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data (combinational) |
| load_sel | input | 1 | 1 selects the memory-load path, 0 selects host writes |
| ld_valid | input | 1 | Memory-load strobe |
| ld_data | input | 8 | Memory-load data byte |
| strap_pwr_pol | input | 1 | Power-polarity strap |
| strap_auto_off | input | 1 | Automatic-mode disable strap |
| otp_fast_div | input | 1 | Fused default for bit 4 |
| otp_attach_det | input | 1 | Fused default for bit 3 |
| up_conn | input | 1 | Upstream port connected |
| port_chg_en | input | NPORT | Per-port charging enable |
| pwr_req | input | NPORT | Per-port power-on request |
| pwr_ctl | output | NPORT | Per-port power-switch control after polarity |
| port_mode | output | 2*NPORT | Per-port charging mode, port i in bits [2i+1:2i] |
| fast_div_sel | output | 1 | High-current divider selected |
| attach_det_en | output | 1 | Device-attach detection active |

## Verification
Some rules are checked by assertions on every cycle:
- the zero reserved bits and zero reads at other addresses;
- the mirroring of the fused defaults while custom is clear;
- the per-port mode table, including the port-0 exception;
- the polarity relation on `pwr_ctl`;
- that no field moves without an accepted write or a strap capture.

Other behaviour needs the bench's sequences:
- the write priority over straps in the release cycle;
- that a write setting custom also carries bits 4 and 3;
- that the unselected load path is ignored.

The decoder and polarity sweeps cover every enable pattern against both connection states and both automatic settings.

// File: rtl/chgcfg_pkg.sv
package chgcfg_pkg;

    typedef enum logic [1:0] {
        CHG_OFF  = 2'b00,
        CHG_DCP  = 2'b01,
        CHG_CDP  = 2'b10,
        CHG_AUTO = 2'b11
    } chg_mode_e;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } cfg_state_e;

    localparam int B_CUSTOM = 6;
    localparam int B_POL    = 5;
    localparam int B_FAST   = 4;
    localparam int B_ATT    = 3;
    localparam int B_SPARE  = 2;
    localparam int B_AUTOFF = 1;

endpackage

// File: rtl/chgcfg_regs.sv
module chgcfg_regs
    import chgcfg_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 4'hA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    input  logic              load_sel,
    input  logic              ld_valid,
    input  logic [7:0]        ld_data,
    input  logic              strap_pwr_pol,
    input  logic              strap_auto_off,
    input  logic              otp_fast_div,
    input  logic              otp_attach_det,
    output logic [7:0]        cfg_byte,
    output logic              pol,
    output logic              auto_off,
    output logic              fast_eff,
    output logic              att_eff
);

    cfg_state_e state_q, state_nx;

    logic       custom_q, pol_q, fast_q, att_q, spare_q, autoff_q;
    logic       wr_acc;
    logic [7:0] wr_byte;

    // write path selection
    always_comb begin
        if (load_sel) begin
            wr_acc  = ld_valid;
            wr_byte = ld_data;
        end else begin
            wr_acc  = bus_we && (bus_addr == CFG_ADDR);
            wr_byte = bus_wdata;
        end
    end

    // sequencer state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HOLD;
        else     state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HOLD: state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
        endcase
    end

    // field storage
    always_ff @(posedge clk) begin
        if (rst) begin
            custom_q <= 1'b0;
            pol_q    <= 1'b0;
            fast_q   <= 1'b0;
            att_q    <= 1'b0;
            spare_q  <= 1'b0;
            autoff_q <= 1'b0;
        end else if (wr_acc) begin
            custom_q <= wr_byte[B_CUSTOM];
            pol_q    <= wr_byte[B_POL];
            spare_q  <= wr_byte[B_SPARE];
            autoff_q <= wr_byte[B_AUTOFF];
            if (wr_byte[B_CUSTOM]) begin
                fast_q <= wr_byte[B_FAST];
                att_q  <= wr_byte[B_ATT];
            end
        end else if (state_q == ST_HOLD) begin
            pol_q    <= strap_pwr_pol;
            autoff_q <= strap_auto_off;
        end
    end

    // effective field values and readback
    always_comb begin
        fast_eff = custom_q ? fast_q : otp_fast_div;
        att_eff  = custom_q ? att_q  : otp_attach_det;
        pol      = pol_q;
        auto_off = autoff_q;
        cfg_byte = '0;
        cfg_byte[B_CUSTOM] = custom_q;
        cfg_byte[B_POL]    = pol_q;
        cfg_byte[B_FAST]   = fast_eff;
        cfg_byte[B_ATT]    = att_eff;
        cfg_byte[B_SPARE]  = spare_q;
        cfg_byte[B_AUTOFF] = autoff_q;
    end

endmodule

// File: rtl/chgcfg_port_dec.sv
module chgcfg_port_dec
    import chgcfg_pkg::*;
#(
    parameter bit IS_FIRST = 1'b0
) (
    input  logic      chg_en,
    input  logic      up_conn,
    input  logic      auto_off,
    output chg_mode_e mode
);

    always_comb begin
        if (!chg_en) begin
            mode = CHG_OFF;
        end else if (up_conn) begin
            if (IS_FIRST && !auto_off) mode = CHG_OFF;
            else                       mode = CHG_CDP;
        end else begin
            mode = auto_off ? CHG_DCP : CHG_AUTO;
        end
    end

endmodule

// File: rtl/chgcfg_pwr_pol.sv
module chgcfg_pwr_pol #(
    parameter int NPORT = 4
) (
    input  logic             pol,
    input  logic [NPORT-1:0] pwr_req,
    output logic [NPORT-1:0] pwr_ctl
);

    always_comb pwr_ctl = pwr_req ^ {NPORT{~pol}};

endmodule

// File: rtl/chgcfg_top.sv
module chgcfg_top
    import chgcfg_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 4'hA
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic                 load_sel,
    input  logic                 ld_valid,
    input  logic [7:0]           ld_data,
    input  logic                 strap_pwr_pol,
    input  logic                 strap_auto_off,
    input  logic                 otp_fast_div,
    input  logic                 otp_attach_det,
    input  logic                 up_conn,
    input  logic [NPORT-1:0]     port_chg_en,
    input  logic [NPORT-1:0]     pwr_req,
    output logic [NPORT-1:0]     pwr_ctl,
    output logic [2*NPORT-1:0]   port_mode,
    output logic                 fast_div_sel,
    output logic                 attach_det_en
);

    logic [7:0] cfg_byte;
    logic       pol_w, autoff_w, fast_w, att_w;

    chgcfg_regs #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_regs (
        .clk            (clk),
        .rst            (rst),
        .bus_addr       (bus_addr),
        .bus_we         (bus_we),
        .bus_wdata      (bus_wdata),
        .load_sel       (load_sel),
        .ld_valid       (ld_valid),
        .ld_data        (ld_data),
        .strap_pwr_pol  (strap_pwr_pol),
        .strap_auto_off (strap_auto_off),
        .otp_fast_div   (otp_fast_div),
        .otp_attach_det (otp_attach_det),
        .cfg_byte       (cfg_byte),
        .pol            (pol_w),
        .auto_off       (autoff_w),
        .fast_eff       (fast_w),
        .att_eff        (att_w)
    );

    always_comb bus_rdata = (bus_addr == CFG_ADDR) ? cfg_byte : 8'h00;

    chgcfg_pwr_pol #(.NPORT(NPORT)) u_pol (
        .pol     (pol_w),
        .pwr_req (pwr_req),
        .pwr_ctl (pwr_ctl)
    );

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        chg_mode_e mode_i;
        chgcfg_port_dec #(.IS_FIRST(i == 0)) u_dec (
            .chg_en   (port_chg_en[i]),
            .up_conn  (up_conn),
            .auto_off (autoff_w),
            .mode     (mode_i)
        );
        assign port_mode[2*i +: 2] = mode_i;
    end

    always_comb begin
        fast_div_sel  = fast_w;
        attach_det_en = att_w & ~autoff_w;
    end

endmodule

// File: rtl/chgcfg_sva.sv
module chgcfg_sva #(
    parameter int NPORT  = 4,
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 4'hA
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [7:0]         bus_rdata,
    input logic               load_sel,
    input logic               ld_valid,
    input logic               strap_pwr_pol,
    input logic               strap_auto_off,
    input logic               otp_fast_div,
    input logic               otp_attach_det,
    input logic               up_conn,
    input logic [NPORT-1:0]   port_chg_en,
    input logic [NPORT-1:0]   pwr_req,
    input logic [NPORT-1:0]   pwr_ctl,
    input logic [2*NPORT-1:0] port_mode,
    input logic               attach_det_en,
    input logic               pol,
    input logic               auto_off
);

    logic wr_now;
    always_comb wr_now = load_sel ? ld_valid : (bus_we && bus_addr == CFG_ADDR);

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == CFG_ADDR) |-> (!bus_rdata[7] && !bus_rdata[0]));

    a_r1_other_addr: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != CFG_ADDR) |-> (bus_rdata == 8'h00));

    a_r2_mirror_otp: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == CFG_ADDR && !bus_rdata[6]) |->
        (bus_rdata[4] == otp_fast_div && bus_rdata[3] == otp_attach_det));

    a_r4_strap_capture: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !wr_now) |=>
        (pol == $past(strap_pwr_pol) && auto_off == $past(strap_auto_off)));

    a_r5_no_stray_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !wr_now) |=> ($stable(pol) && $stable(auto_off)));

    a_r6_polarity: assert property (@(posedge clk) disable iff (rst)
        pwr_ctl == (pol ? pwr_req : ~pwr_req));

    a_r10_attach_gate: assert property (@(posedge clk) disable iff (rst)
        attach_det_en |-> !auto_off);

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        a_r7_disabled_off: assert property (@(posedge clk) disable iff (rst)
            !port_chg_en[i] |-> (port_mode[2*i +: 2] == 2'b00));

        a_r8_disconnected: assert property (@(posedge clk) disable iff (rst)
            (port_chg_en[i] && !up_conn) |->
            (port_mode[2*i +: 2] == (auto_off ? 2'b01 : 2'b11)));

        if (i == 0) begin : g_first
            a_r9_first_port: assert property (@(posedge clk) disable iff (rst)
                (port_chg_en[i] && up_conn) |->
                (port_mode[2*i +: 2] == (auto_off ? 2'b10 : 2'b00)));
        end else begin : g_rest
            a_r9_connected: assert property (@(posedge clk) disable iff (rst)
                (port_chg_en[i] && up_conn) |-> (port_mode[2*i +: 2] == 2'b10));
        end
    end

endmodule

bind chgcfg_top chgcfg_sva #(.NPORT(NPORT), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_sva (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_rdata      (bus_rdata),
    .load_sel       (load_sel),
    .ld_valid       (ld_valid),
    .strap_pwr_pol  (strap_pwr_pol),
    .strap_auto_off (strap_auto_off),
    .otp_fast_div   (otp_fast_div),
    .otp_attach_det (otp_attach_det),
    .up_conn        (up_conn),
    .port_chg_en    (port_chg_en),
    .pwr_req        (pwr_req),
    .pwr_ctl        (pwr_ctl),
    .port_mode      (port_mode),
    .attach_det_en  (attach_det_en),
    .pol            (pol_w),
    .auto_off       (autoff_w)
);

// File: tb/sim_chgcfg_top.sv
module sim_chgcfg_top;

    localparam int CLK_PERIOD = 10;
    localparam int NPORT = 4;
    localparam int ADDR_W = 4;
    localparam logic [3:0] CFG = 4'hA;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] bus_addr = CFG;
    logic bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic load_sel = 1'b0, ld_valid = 1'b0;
    logic [7:0] ld_data = 8'h00;
    logic strap_pwr_pol = 1'b1, strap_auto_off = 1'b0;
    logic otp_fast_div = 1'b1, otp_attach_det = 1'b0;
    logic up_conn = 1'b0;
    logic [3:0] port_chg_en = 4'h0, pwr_req = 4'h0, pwr_ctl;
    logic [7:0] port_mode;
    logic fast_div_sel, attach_det_en;

    int n_vec = 0, n_bad = 0;
    bit m_custom, m_pol, m_fast, m_att, m_spare, m_autoff;

    always #(CLK_PERIOD/2) clk = ~clk;

    chgcfg_top u0 (.*);

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte();
        return {1'b0, m_custom, m_pol,
                m_custom ? m_fast : otp_fast_div,
                m_custom ? m_att : otp_attach_det,
                m_spare, m_autoff, 1'b0};
    endfunction

    function automatic logic [1:0] exp_mode(input int p, input bit en);
        if (!en) return 2'b00;
        if (up_conn) return (p == 0 && !m_autoff) ? 2'b00 : 2'b10;
        return m_autoff ? 2'b01 : 2'b11;
    endfunction

    task automatic model_apply(input logic [7:0] b);
        m_custom = b[6]; m_pol = b[5]; m_spare = b[2]; m_autoff = b[1];
        if (b[6]) begin m_fast = b[4]; m_att = b[3]; end
    endtask

    task automatic host_wr(input logic [7:0] b);
        @(negedge clk);
        load_sel = 1'b0; bus_addr = CFG; bus_we = 1'b1; bus_wdata = b;
        @(negedge clk);
        bus_we = 1'b0;
        model_apply(b);
    endtask

    task automatic ld_wr(input logic [7:0] b);
        @(negedge clk);
        load_sel = 1'b1; ld_valid = 1'b1; ld_data = b;
        @(negedge clk);
        ld_valid = 1'b0;
        model_apply(b);
    endtask

    task automatic reg_check(input string tag);
        bus_addr = CFG; #1;
        check(tag, bus_rdata, exp_byte());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R4 reset and strap capture
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        m_custom = 0; m_fast = 0; m_att = 0; m_spare = 0;
        m_pol = 1; m_autoff = 0;
        reg_check("R4 strap capture");

        // R4 write in release cycle wins over straps
        rst = 1'b1; strap_pwr_pol = 1'b1; strap_auto_off = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; load_sel = 1'b0; bus_addr = CFG; bus_we = 1'b1; bus_wdata = 8'h04;
        @(negedge clk);
        bus_we = 1'b0;
        m_custom = 0; m_fast = 0; m_att = 0;
        model_apply(8'h04);
        reg_check("R4 write priority");

        // R1 reserved bits and other address
        host_wr(8'hFF);
        reg_check("R1 all-ones write");
        bus_addr = 4'h3; #1;
        check("R1 other address", bus_rdata, 8'h00);
        host_wr(8'h00);
        reg_check("R1 spare cleared");

        // R2 / R3 / R10 sweep over fused values, custom and written fields
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 2; c++) begin
                for (int v = 0; v < 4; v++) begin
                    otp_fast_div = r[1]; otp_attach_det = r[0];
                    host_wr({1'b0, c[0], 1'b0, v[1], v[0], 3'b000});
                    reg_check(c[0] ? "R3 custom fields" : "R2 otp mirror");
                    check("R10 fast divider", {7'd0, fast_div_sel}, {7'd0, exp_byte()[4]});
                    check("R10 attach detect", {7'd0, attach_det_en},
                          {7'd0, exp_byte()[3] & ~m_autoff});
                end
            end
        end

        // R5 path selection
        host_wr(8'h22);
        @(negedge clk);
        load_sel = 1'b1; bus_addr = CFG; bus_we = 1'b1; bus_wdata = 8'h04;
        @(negedge clk); bus_we = 1'b0;
        reg_check("R5 host ignored in load mode");
        ld_wr(8'h5C);
        reg_check("R5 load path write");
        @(negedge clk);
        load_sel = 1'b0; ld_valid = 1'b1; ld_data = 8'h02;
        @(negedge clk); ld_valid = 1'b0;
        reg_check("R5 load ignored in host mode");
        @(negedge clk);
        bus_addr = 4'h9; bus_we = 1'b1; bus_wdata = 8'h26;
        @(negedge clk); bus_we = 1'b0;
        reg_check("R5 other address write ignored");

        // R6 polarity sweep
        for (int p = 0; p < 2; p++) begin
            host_wr({2'b00, p[0], 5'b00000});
            for (int q = 0; q < 16; q++) begin
                pwr_req = q[3:0]; #1;
                check("R6 power polarity", {4'd0, pwr_ctl},
                      {4'd0, p[0] ? q[3:0] : ~q[3:0]});
            end
        end

        // R7 / R8 / R9 decoder sweep
        for (int a = 0; a < 2; a++) begin
            host_wr({6'b000000, a[0], 1'b0});
            for (int u = 0; u < 2; u++) begin
                up_conn = u[0];
                for (int e = 0; e < 16; e++) begin
                    port_chg_en = e[3:0]; #1;
                    for (int i = 0; i < NPORT; i++) begin
                        check(!e[i] ? "R7 disabled port" : (u[0] ? "R9 connected" : "R8 disconnected"),
                              {6'd0, port_mode[2*i +: 2]}, {6'd0, exp_mode(i, e[i])});
                    end
                end
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule